// File: doc/BRIEF.md
# Converter Sample Rate Register Bank

This block holds the sample-rate settings of a multichannel audio codec: one rate for the front DAC pair, one for the surround DAC pair, one for the LFE/centre DAC pair and one for the stereo ADC. Each setting is an unsigned 16-bit value in Hz. A host reaches the settings through a small indexed register port with a write strobe, an 8-bit index, write data and combinational read data. Each converter reads its effective rate from a dedicated output.

Two mode inputs shape the behaviour. The variable-rate enable pins every converter to 48 kHz while it is low, and it wipes the stored settings back to that value. The rate-unlock input decides whether the surround and LFE/centre converters run at their own rate or simply follow the front DAC rate. The ADC rate never follows the front rate. Written values are clamped into the 7000–48000 Hz window.

Top module: `rate_bank`

## Requirements
- R1: After a synchronous active-low reset, all four stored rates are 48000 (BB80h), and every rate output and every rate index reads BB80h.
- R2: Index 2Ch is the front rate, 2Eh the surround rate, 30h the LFE/centre rate and 32h the ADC rate. A read returns the current effective rate combinationally. A write takes effect at the next clock edge and is visible from that point on.
- R3: A written value below 7000 (1B58h) is stored as 7000, a value above 48000 (BB80h) is stored as 48000, and values in between, including both limits, are stored unchanged.
- R4: While var_rate_en is low, all four rate outputs and all four rate indices give BB80h, and writes have no effect. After var_rate_en returns high, every stored rate is 48000.
- R5: While rate_unlock is low, the surround and LFE/centre outputs and their indices return the front rate, and writes to 2Eh or 30h have no effect.
- R6: While rate_unlock is high, the surround and LFE/centre rates are independently writable. Each one starts from the front rate that was in force when the unlock began, and it keeps its own value when the front rate changes.
- R7: When rate_unlock goes low again, the surround and LFE/centre rates immediately follow the front rate once more.
- R8: The ADC rate is never tied to the front rate. Writes to the front index, and changes of rate_unlock, leave it unchanged.
- R9: A read from any index other than 2Ch, 2Eh, 30h or 32h returns 0000h. A write to such an index changes no rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write strobe for the indexed port |
| reg_index | input | 8 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_index (combinational) |
| var_rate_en | input | 1 | Variable-rate enable; low forces 48 kHz |
| rate_unlock | input | 1 | High lets surround and LFE/centre rates be set on their own |
| front_rate | output | 16 | Effective front DAC rate |
| surr_rate | output | 16 | Effective surround DAC rate |
| lfe_rate | output | 16 | Effective LFE/centre DAC rate |
| adc_rate | output | 16 | Effective ADC rate |

## Verification
Mode inputs act with zero delay: a change of var_rate_en or rate_unlock shows on the outputs and on reg_rdata in the same cycle. A write shows exactly one clock edge later. The bench therefore drives inputs on the falling edge and compares all outputs and the read data 1 ns later. It checks against a model state that it advances only at the rising edge, so the same-cycle effects and the one-edge write latency are both checked every cycle.

// File: rtl/rate_pkg.sv
// Shared constants and types for the sample-rate register bank.
// Assumes rates are 16-bit unsigned values in Hz.
package rate_pkg;
    localparam int RATE_W = 16;
    localparam logic [RATE_W-1:0] RATE_DEFAULT = 16'hBB80; // 48000 Hz
    localparam logic [RATE_W-1:0] RATE_LOW     = 16'h1B58; // 7000 Hz
    localparam logic [RATE_W-1:0] RATE_HIGH    = 16'hBB80; // 48000 Hz

    typedef logic [RATE_W-1:0] rate_t;

    // Channel slots in the bank; slot 0 is the one others may follow.
    typedef enum logic [1:0] {
        CH_FRONT = 2'd0,
        CH_SURR  = 2'd1,
        CH_LFE   = 2'd2,
        CH_ADC   = 2'd3
    } chan_e;

    localparam int NUM_CH = 4;
endpackage

// File: rtl/rate_limit.sv
// Saturates a requested rate into the window [LOW, HIGH].
// Purely combinational; assumes LOW <= HIGH.
module rate_limit #(
    parameter int W = 16,
    parameter logic [W-1:0] LOW  = 16'h1B58,
    parameter logic [W-1:0] HIGH = 16'hBB80
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] val_o
);
    // Pick the nearer limit when the request falls outside the window.
    always_comb begin
        if (req_i < LOW)       val_o = LOW;
        else if (req_i > HIGH) val_o = HIGH;
        else                   val_o = req_i;
    end
endmodule

// File: rtl/rate_decode.sv
// Turns a register index and write strobe into per-slot select lines.
// Assumes the slot indices are distinct.
module rate_decode #(
    parameter int AW = 8,
    parameter int N  = 4,
    parameter logic [N*AW-1:0] INDICES = {8'h32, 8'h30, 8'h2E, 8'h2C}
) (
    input  logic          we_i,
    input  logic [AW-1:0] index_i,
    output logic [N-1:0]  sel_o,
    output logic [N-1:0]  wr_o,
    output logic          known_o
);
    // One comparator per slot; a write strobe qualifies each match.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign sel_o[g] = (index_i == INDICES[g*AW +: AW]);
        assign wr_o[g]  = we_i && sel_o[g];
    end

    // Flags an index that belongs to the bank.
    assign known_o = |sel_o;
endmodule

// File: rtl/rate_slot.sv
// One stored rate with its effective-value logic.
// When LOCKABLE is set and unlock is low, the slot follows a lead slot:
// its stored value copies the lead's next value and its output is the
// lead's effective value. A low enable forces DEFAULT and blocks writes.
module rate_slot #(
    parameter int W = 16,
    parameter bit LOCKABLE = 1'b0,
    parameter logic [W-1:0] DEFAULT = 16'hBB80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         unlock_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_val_i,
    input  logic [W-1:0] lead_nxt_i,
    input  logic [W-1:0] lead_eff_i,
    output logic [W-1:0] nxt_o,
    output logic [W-1:0] eff_o
);
    logic [W-1:0] q;
    logic         follow;

    // Whether this slot currently tracks the lead slot.
    if (LOCKABLE) begin : g_lock
        assign follow = !unlock_i;
    end else begin : g_free
        logic unused_lead;
        assign unused_lead = unlock_i ^ (^lead_nxt_i) ^ (^lead_eff_i);
        assign follow = 1'b0;
    end

    // Next stored value: default, lead copy, new write, or hold.
    always_comb begin
        if (!en_i)       nxt_o = DEFAULT;
        else if (follow) nxt_o = lead_nxt_i;
        else if (wr_i)   nxt_o = wr_val_i;
        else             nxt_o = q;
    end

    // Storage register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= DEFAULT;
        else        q <= nxt_o;
    end

    // Value the converter sees in this cycle.
    always_comb begin
        if (!en_i)       eff_o = DEFAULT;
        else if (follow) eff_o = lead_eff_i;
        else             eff_o = q;
    end
endmodule

// File: rtl/rate_bank.sv
// Top of the sample-rate register bank: four rate slots behind an
// indexed read/write port. Slots 1 and 2 may follow slot 0; slot 3 is
// always free. Assumes a single clock and synchronous active-low reset.
module rate_bank #(
    parameter int AW = 8,
    parameter logic [AW-1:0] IDX_FRONT = 8'h2C,
    parameter logic [AW-1:0] IDX_SURR  = 8'h2E,
    parameter logic [AW-1:0] IDX_LFE   = 8'h30,
    parameter logic [AW-1:0] IDX_ADC   = 8'h32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [AW-1:0] reg_index,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        var_rate_en,
    input  logic        rate_unlock,
    output logic [15:0] front_rate,
    output logic [15:0] surr_rate,
    output logic [15:0] lfe_rate,
    output logic [15:0] adc_rate
);
    import rate_pkg::*;

    localparam int N = NUM_CH;
    localparam logic [N*AW-1:0] IDX_ALL = {IDX_ADC, IDX_LFE, IDX_SURR, IDX_FRONT};

    logic [N-1:0]        sel;
    logic [N-1:0]        wr;
    logic                known;
    rate_t               wr_val;
    logic [N-1:0][RATE_W-1:0] nxt;
    logic [N-1:0][RATE_W-1:0] eff;

    rate_limit #(.W(RATE_W), .LOW(RATE_LOW), .HIGH(RATE_HIGH)) u_limit (
        .req_i (reg_wdata),
        .val_o (wr_val)
    );

    rate_decode #(.AW(AW), .N(N), .INDICES(IDX_ALL)) u_decode (
        .we_i    (reg_we),
        .index_i (reg_index),
        .sel_o   (sel),
        .wr_o    (wr),
        .known_o (known)
    );

    // Slot array; slot 0 leads, middle slots lockable, last slot free.
    for (genvar g = 0; g < N; g++) begin : g_slot
        localparam bit LK = (g == int'(CH_SURR)) || (g == int'(CH_LFE));
        logic [RATE_W-1:0] lead_nxt;
        logic [RATE_W-1:0] lead_eff;
        if (g == int'(CH_FRONT)) begin : g_lead
            assign lead_nxt = '0;
            assign lead_eff = '0;
        end else begin : g_tail
            assign lead_nxt = nxt[CH_FRONT];
            assign lead_eff = eff[CH_FRONT];
        end
        rate_slot #(.W(RATE_W), .LOCKABLE(LK), .DEFAULT(RATE_DEFAULT)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (var_rate_en),
            .unlock_i   (rate_unlock),
            .wr_i       (wr[g]),
            .wr_val_i   (wr_val),
            .lead_nxt_i (lead_nxt),
            .lead_eff_i (lead_eff),
            .nxt_o      (nxt[g]),
            .eff_o      (eff[g])
        );
    end

    assign front_rate = eff[CH_FRONT];
    assign surr_rate  = eff[CH_SURR];
    assign lfe_rate   = eff[CH_LFE];
    assign adc_rate   = eff[CH_ADC];

    // Read mux: effective rate of the selected slot, zero for unknown index.
    always_comb begin
        reg_rdata = '0;
        if (known) begin
            for (int k = 0; k < N; k++) begin
                if (sel[k]) reg_rdata = eff[k];
            end
        end
    end
endmodule

// File: rtl/rate_bank_chk.sv
// Property checker for rate_bank, attached through bind.
// Assumes the default index map of the top module.
module rate_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_index,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        var_rate_en,
    input logic        rate_unlock,
    input logic [15:0] front_rate,
    input logic [15:0] surr_rate,
    input logic [15:0] lfe_rate,
    input logic [15:0] adc_rate
);
    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (front_rate == 16'hBB80 && surr_rate == 16'hBB80 &&
                    lfe_rate == 16'hBB80 && adc_rate == 16'hBB80));

    // R2
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_index == 8'h2C && var_rate_en &&
         reg_wdata >= 16'h1B58 && reg_wdata <= 16'hBB80)
        |=> (!var_rate_en || front_rate == $past(reg_wdata)));

    // R3
    rate_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (front_rate >= 16'h1B58 && front_rate <= 16'hBB80 &&
         adc_rate >= 16'h1B58 && adc_rate <= 16'hBB80));

    // R4
    forced_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !var_rate_en |-> (front_rate == 16'hBB80 && surr_rate == 16'hBB80 &&
                          lfe_rate == 16'hBB80 && adc_rate == 16'hBB80));

    // R5
    locked_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_unlock |-> (surr_rate == front_rate && lfe_rate == front_rate));

    // R8
    adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (var_rate_en && !(reg_we && reg_index == 8'h32))
        |=> (!var_rate_en || $stable(adc_rate)));

    // R9
    unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_index != 8'h2C && reg_index != 8'h2E &&
         reg_index != 8'h30 && reg_index != 8'h32) |-> reg_rdata == 16'h0000);
endmodule

bind rate_bank rate_bank_chk u_rate_bank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_index   (reg_index),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .var_rate_en (var_rate_en),
    .rate_unlock (rate_unlock),
    .front_rate  (front_rate),
    .surr_rate   (surr_rate),
    .lfe_rate    (lfe_rate),
    .adc_rate    (adc_rate)
);

// File: tb/test_rate_bank.sv
`timescale 1ns/1ps
module test_rate_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_index = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        var_rate_en = 1'b1;
    logic        rate_unlock = 1'b0;
    logic [15:0] front_rate, surr_rate, lfe_rate, adc_rate;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state (plain integers, advanced at rising edges).
    int m_front = 48000, m_surr = 48000, m_lfe = 48000, m_adc = 48000;

    always #2.5 clk = ~clk;

    rate_bank i_rate_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_index(reg_index),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .var_rate_en(var_rate_en), .rate_unlock(rate_unlock),
        .front_rate(front_rate), .surr_rate(surr_rate),
        .lfe_rate(lfe_rate), .adc_rate(adc_rate)
    );

    function automatic int lim(input int v);
        if (v < 7000) return 7000;
        if (v > 48000) return 48000;
        return v;
    endfunction

    function automatic int e_front();
        return var_rate_en ? m_front : 48000;
    endfunction
    function automatic int e_surr();
        if (!var_rate_en) return 48000;
        return rate_unlock ? m_surr : m_front;
    endfunction
    function automatic int e_lfe();
        if (!var_rate_en) return 48000;
        return rate_unlock ? m_lfe : m_front;
    endfunction
    function automatic int e_adc();
        return var_rate_en ? m_adc : 48000;
    endfunction
    function automatic int e_read();
        case (reg_index)
            8'h2C: return e_front();
            8'h2E: return e_surr();
            8'h30: return e_lfe();
            8'h32: return e_adc();
            default: return 0;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare 1 ns later, advance model at rising edge.
    task automatic cyc(input string tag, input bit we, input logic [7:0] idx,
                       input int data, input bit en, input bit un);
        int nf, ns, nl, na, wv;
        @(negedge clk);
        reg_we = we; reg_index = idx; reg_wdata = 16'(data);
        var_rate_en = en; rate_unlock = un;
        #1;
        cmp(tag, "rdata", int'(reg_rdata), e_read());
        cmp(tag, "front", int'(front_rate), e_front());
        cmp(tag, "surr",  int'(surr_rate),  e_surr());
        cmp(tag, "lfe",   int'(lfe_rate),   e_lfe());
        cmp(tag, "adc",   int'(adc_rate),   e_adc());
        @(posedge clk);
        wv = lim(data);
        if (!en) begin
            m_front = 48000; m_surr = 48000; m_lfe = 48000; m_adc = 48000;
        end else begin
            nf = (we && idx == 8'h2C) ? wv : m_front;
            na = (we && idx == 8'h32) ? wv : m_adc;
            ns = un ? ((we && idx == 8'h2E) ? wv : m_surr) : nf;
            nl = un ? ((we && idx == 8'h30) ? wv : m_lfe) : nf;
            m_front = nf; m_surr = ns; m_lfe = nl; m_adc = na;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state on every index
        cyc("R1", 0, 8'h2C, 0, 1, 0);
        cyc("R1", 0, 8'h2E, 0, 1, 0);
        cyc("R1", 0, 8'h30, 0, 1, 0);
        cyc("R1", 0, 8'h32, 0, 1, 0);
        // R2 writes visible next edge
        cyc("R2", 1, 8'h2C, 22050, 1, 0);
        cyc("R2", 0, 8'h2C, 0, 1, 0);
        cyc("R2", 1, 8'h32, 16000, 1, 0);
        cyc("R2", 0, 8'h32, 0, 1, 0);
        // R3 clamping and exact limits
        cyc("R3", 1, 8'h2C, 5000, 1, 0);
        cyc("R3", 1, 8'h2C, 60000, 1, 0);
        cyc("R3", 1, 8'h32, 6999, 1, 0);
        cyc("R3", 1, 8'h2C, 7000, 1, 0);
        cyc("R3", 1, 8'h32, 48000, 1, 0);
        cyc("R3", 1, 8'h2C, 48001, 1, 0);
        cyc("R3", 0, 8'h2C, 0, 1, 0);
        // R5 locked: writes ignored, reads follow front
        cyc("R5", 1, 8'h2E, 11025, 1, 0);
        cyc("R5", 1, 8'h30, 8000, 1, 0);
        cyc("R5", 0, 8'h2E, 0, 1, 0);
        cyc("R5", 0, 8'h30, 0, 1, 0);
        // R8 front write leaves ADC alone
        cyc("R8", 1, 8'h2C, 32000, 1, 0);
        cyc("R8", 0, 8'h32, 0, 1, 0);
        // R6 unlock starts from front, then independent
        cyc("R6", 0, 8'h2E, 0, 1, 1);
        cyc("R6", 1, 8'h2E, 44100, 1, 1);
        cyc("R6", 1, 8'h30, 8000, 1, 1);
        cyc("R6", 1, 8'h2C, 24000, 1, 1);
        cyc("R6", 0, 8'h2E, 0, 1, 1);
        cyc("R6", 0, 8'h30, 0, 1, 1);
        // R7 relock follows front at once
        cyc("R7", 0, 8'h2E, 0, 1, 0);
        cyc("R7", 0, 8'h30, 0, 1, 0);
        cyc("R8", 0, 8'h32, 0, 1, 1);
        // R9 unknown indices
        cyc("R9", 0, 8'h00, 0, 1, 0);
        cyc("R9", 1, 8'h31, 12345, 1, 0);
        cyc("R9", 1, 8'h2D, 9000, 1, 0);
        cyc("R9", 0, 8'hFF, 0, 1, 0);
        cyc("R9", 0, 8'h2C, 0, 1, 0);
        cyc("R9", 0, 8'h32, 0, 1, 0);
        // R4 enable low forces default and blocks writes
        cyc("R4", 1, 8'h2C, 8000, 1, 1);
        cyc("R4", 1, 8'h30, 9000, 1, 1);
        cyc("R4", 0, 8'h2C, 0, 0, 1);
        cyc("R4", 1, 8'h32, 10000, 0, 1);
        cyc("R4", 0, 8'h30, 0, 0, 0);
        cyc("R4", 0, 8'h2C, 0, 1, 1);
        cyc("R4", 0, 8'h30, 0, 1, 1);
        cyc("R4", 0, 8'h32, 0, 1, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule